// File: doc/BRIEF.md
# DDR3 Burst Column Order Generator

This block expands one column read or write command into the ordered column indices of its burst, one beat per clock. A command carries a read/write flag, the low three starting column bits, a sequential-or-interleaved select and a full-burst-or-chop select. Every accepted command fills exactly eight beat slots on eight consecutive cycles. A 4-beat chop uses the same slot timing as a full 8-beat burst and pads the second half with tri-stated or don't-care slots.

Reads use the full starting address to order the beats. Writes mask part of it. A full write always runs in ascending order. A chopped write keeps only the top starting bit. For each slot the block gives the column index, a drive-enable for data and strobe, and a don't-care marker. The beat output is a fixed-rate stream with no ready input and no back-pressure: the consumer takes each valid beat on the cycle it is shown. Before accepting a new command, a bus master must wait for the final slot of the previous burst, or for idle.

Top module: `ddr3_burst_order`

## Requirements
- R1: While synchronous reset `rst` is high, including a reset in the middle of a burst, the cycle after the reset edge shows `beat_valid`, `beat_drive`, `beat_dc` and `cmd_err` all low.
- R2: For a read with `cmd_ilv`=0 (sequential) and `cmd_chop`=0, beat i has low two bits (start[1:0]+i) mod 4 and bit 2 equal to start[2] XOR i[2]. A start of 5 gives 5,6,7,4,1,2,3,0.
- R3: For a read with `cmd_ilv`=1 (interleaved) and `cmd_chop`=0, beat i has index start XOR i. A start of 5 gives 5,4,7,6,1,0,3,2.
- R4: For a write (`cmd_rd`=0) with `cmd_chop`=0, the order is 0,1,...,7 for every start value and for both burst types.
- R5: For a read with `cmd_chop`=1, beats 0–3 follow the R2 or R3 rule with the full 3-bit start. Beats 4–7 show `beat_drive`=0 and `beat_dc`=1.
- R6: For a write with `cmd_chop`=1, start bits [1:0] are ignored and beats 0–3 are {start[2],0..3}. Beats 4–7 show `beat_dc`=1 and `beat_drive`=1.
- R7: A command accepted at a clock edge gives `beat_valid` high for exactly the eight following cycles, chopped or not. `beat_valid` then falls unless another command was accepted.
- R8: A command strobe during the last slot (beat 7) is accepted. Its beat 0 follows on the next cycle with no gap.
- R9: A command strobe during slots 0–6 is ignored. The running burst continues unchanged, and `cmd_err` is high on the next cycle.
- R10: While `beat_valid` is low, `beat_drive` and `beat_dc` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_rd | input | 1 | 1 = read, 0 = write |
| cmd_ilv | input | 1 | 1 = interleaved, 0 = sequential order |
| cmd_chop | input | 1 | 1 = 4-beat chop, 0 = full 8-beat burst |
| cmd_col | input | COL_W (3) | Starting column bits [2:0] |
| beat_valid | output | 1 | A beat slot is being presented |
| beat_col | output | COL_W (3) | Column index of the current beat |
| beat_drive | output | 1 | Data and strobe drivers enabled for this slot |
| beat_dc | output | 1 | Slot content is don't-care |
| cmd_err | output | 1 | Previous cycle held a rejected strobe |

## Verification
The assertions assume that `rst` is high at the first clock edge. They also assume that the command fields are known whenever `cmd_valid` is high, because the fields are only captured on an accepted strobe. The bench holds reset over the first edges. It changes inputs only on falling edges and raises `cmd_valid` for a single cycle, with every field set to a defined value. Strobes that overlap a burst are placed on purpose, both in a middle slot and in the final slot, to reach the reject path and the chaining path.

// File: rtl/bo_pkg.sv
package bo_pkg;

  // Captured command mode bits.
  typedef struct packed {
    logic rd;    // 1 = read
    logic ilv;   // 1 = interleaved
    logic chop;  // 1 = 4-beat chop
  } bo_mode_t;

  // What a beat slot carries.
  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,  // no burst
    SLOT_DATA = 2'd1,  // real beat
    SLOT_HIZ  = 2'd2,  // read chop pad, drivers off
    SLOT_MASK = 2'd3   // write chop pad, content ignored
  } bo_slot_e;

endpackage

// File: rtl/bo_sequencer.sv
module bo_sequencer
  import bo_pkg::*;
#(
  parameter int BL    = 8,
  parameter int COL_W = $clog2(BL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  bo_mode_t         cmd_mode,
  input  logic [COL_W-1:0] cmd_start,
  output logic             active,
  output logic [COL_W-1:0] beat,
  output bo_mode_t         mode,
  output logic [COL_W-1:0] start,
  output logic             err
);

  localparam logic [COL_W-1:0] LAST = COL_W'(BL - 1);

  logic at_last;
  logic accept;

  assign at_last = active && (beat == LAST);
  assign accept  = cmd_valid && (!active || at_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      beat   <= '0;
      mode   <= '0;
      start  <= '0;
      err    <= 1'b0;
    end else begin
      err <= cmd_valid && !accept;
      if (accept) begin
        active <= 1'b1;
        beat   <= '0;
        mode   <= cmd_mode;
        start  <= cmd_start;
      end else if (active) begin
        if (at_last) begin
          active <= 1'b0;
          beat   <= '0;
        end else begin
          beat <= beat + 1'b1;
        end
      end
    end
  end

  AST_SLOT_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (active && beat != LAST) |=> (active && beat == $past(beat) + 1'b1)); // R7

  AST_CHAIN_NO_GAP: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && active && beat == LAST) |=> (active && beat == '0)); // R8

  AST_BUSY_REJECT: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && active && beat != LAST) |=> (err && start == $past(start) && mode == $past(mode))); // R9

endmodule

// File: rtl/bo_col_map.sv
module bo_col_map
  import bo_pkg::*;
#(
  parameter int BL    = 8,
  parameter int COL_W = $clog2(BL)
) (
  input  bo_mode_t         mode,
  input  logic [COL_W-1:0] start,
  input  logic [COL_W-1:0] beat,
  output logic [COL_W-1:0] col
);

  localparam int LOW_W = COL_W - 1;

  logic [COL_W-1:0] ilv_col;
  logic [COL_W-1:0] seq_col;
  logic [COL_W-1:0] wr_chop_col;
  logic [LOW_W-1:0] low_sum;

  // Interleaved: one XOR per address bit.
  for (genvar g = 0; g < COL_W; g++) begin : g_ilv
    assign ilv_col[g] = start[g] ^ beat[g];
  end

  // Sequential: low bits wrap within a half, top bit toggles per half.
  assign low_sum = start[LOW_W-1:0] + beat[LOW_W-1:0];
  assign seq_col = {start[COL_W-1] ^ beat[COL_W-1], low_sum};

  // Chopped write: only the half select of the start survives.
  assign wr_chop_col = {start[COL_W-1], beat[LOW_W-1:0]};

  always_comb begin
    if (mode.rd) begin
      col = mode.ilv ? ilv_col : seq_col;
    end else if (mode.chop) begin
      col = wr_chop_col;
    end else begin
      col = beat;
    end
  end

endmodule

// File: rtl/bo_slot_class.sv
module bo_slot_class
  import bo_pkg::*;
#(
  parameter int BL    = 8,
  parameter int COL_W = $clog2(BL)
) (
  input  logic             active,
  input  logic             rd,
  input  logic             chop,
  input  logic [COL_W-1:0] beat,
  output bo_slot_e         slot
);

  localparam logic [COL_W-1:0] HALF = COL_W'(BL / 2);

  always_comb begin
    if (!active) begin
      slot = SLOT_IDLE;
    end else if (chop && (beat >= HALF)) begin
      slot = rd ? SLOT_HIZ : SLOT_MASK;
    end else begin
      slot = SLOT_DATA;
    end
  end

endmodule

// File: rtl/ddr3_burst_order.sv
module ddr3_burst_order
  import bo_pkg::*;
#(
  parameter int BL    = 8,
  parameter int COL_W = $clog2(BL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic             cmd_rd,
  input  logic             cmd_ilv,
  input  logic             cmd_chop,
  input  logic [COL_W-1:0] cmd_col,
  output logic             beat_valid,
  output logic [COL_W-1:0] beat_col,
  output logic             beat_drive,
  output logic             beat_dc,
  output logic             cmd_err
);

  bo_mode_t         cmd_mode;
  bo_mode_t         mode_q;
  logic             active_q;
  logic [COL_W-1:0] beat_q;
  logic [COL_W-1:0] start_q;
  logic [COL_W-1:0] mapped_col;
  bo_slot_e         slot;

  assign cmd_mode = '{rd: cmd_rd, ilv: cmd_ilv, chop: cmd_chop};

  bo_sequencer #(.BL(BL), .COL_W(COL_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_mode  (cmd_mode),
    .cmd_start (cmd_col),
    .active    (active_q),
    .beat      (beat_q),
    .mode      (mode_q),
    .start     (start_q),
    .err       (cmd_err)
  );

  bo_col_map #(.BL(BL), .COL_W(COL_W)) u_map (
    .mode  (mode_q),
    .start (start_q),
    .beat  (beat_q),
    .col   (mapped_col)
  );

  bo_slot_class #(.BL(BL), .COL_W(COL_W)) u_cls (
    .active (active_q),
    .rd     (mode_q.rd),
    .chop   (mode_q.chop),
    .beat   (beat_q),
    .slot   (slot)
  );

  always_comb begin
    beat_valid = (slot != SLOT_IDLE);
    beat_drive = (slot == SLOT_DATA) || (slot == SLOT_MASK);
    beat_dc    = (slot == SLOT_HIZ)  || (slot == SLOT_MASK);
    beat_col   = beat_valid ? mapped_col : '0;
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!beat_valid && !cmd_err)); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !beat_valid |-> (!beat_drive && !beat_dc)); // R10

  AST_HIZ_IS_DC: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && !beat_drive) |-> (beat_dc && mode_q.rd && mode_q.chop)); // R5

  AST_WRITE_ASCENDS: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && !mode_q.rd && !mode_q.chop) |-> (beat_col == beat_q)); // R4

  AST_WR_CHOP_HALF: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && !mode_q.rd && mode_q.chop && !beat_dc)
      |-> (beat_col[COL_W-1] == start_q[COL_W-1])); // R6

endmodule

// File: tb/tb_ddr3_burst_order.sv
module tb_ddr3_burst_order;

  logic       clk = 1'b0;
  logic       rst;
  logic       cmd_valid;
  logic       cmd_rd;
  logic       cmd_ilv;
  logic       cmd_chop;
  logic [2:0] cmd_col;
  logic       beat_valid;
  logic [2:0] beat_col;
  logic       beat_drive;
  logic       beat_dc;
  logic       cmd_err;

  int  checks = 0;
  int  errors = 0;
  bit  reported = 0;

  always #2 clk = ~clk;  // 4 ns period

  ddr3_burst_order dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_rd(cmd_rd),
    .cmd_ilv(cmd_ilv), .cmd_chop(cmd_chop), .cmd_col(cmd_col),
    .beat_valid(beat_valid), .beat_col(beat_col), .beat_drive(beat_drive),
    .beat_dc(beat_dc), .cmd_err(cmd_err)
  );

  // [29]=rd [28]=ilv [27]=chop [26:24]=start [23:0]=expected order, beat 0 in top octal digit
  typedef logic [29:0] vec_t;
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    {1'b1, 1'b0, 1'b0, 3'd5, 24'o56741230},  // R2
    {1'b1, 1'b0, 1'b0, 3'd2, 24'o23016745},  // R2
    {1'b1, 1'b1, 1'b0, 3'd5, 24'o54761032},  // R3
    {1'b1, 1'b1, 1'b0, 3'd3, 24'o32107654},  // R3
    {1'b0, 1'b0, 1'b0, 3'd6, 24'o01234567},  // R4
    {1'b0, 1'b1, 1'b0, 3'd3, 24'o01234567},  // R4
    {1'b1, 1'b0, 1'b1, 3'd7, 24'o74560000},  // R5
    {1'b1, 1'b1, 1'b1, 3'd6, 24'o67450000},  // R5
    {1'b0, 1'b0, 1'b1, 3'd3, 24'o01230000},  // R6
    {1'b0, 1'b1, 1'b1, 3'd6, 24'o45670000}   // R6
  };

  function automatic string tag_of(vec_t v);
    if (v[27]) return v[29] ? "R5" : "R6";
    if (!v[29]) return "R4";
    return v[28] ? "R3" : "R2";
  endfunction

  task automatic summary();
    if (!reported) begin
      reported = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
    end
    $finish;
  endtask

  task automatic check_beat(vec_t v, int i, string tag);
    logic [2:0] ec;
    logic       ed;
    logic       edc;
    ec  = v[23 - 3*i -: 3];
    edc = v[27] && (i >= 4);
    ed  = !(v[27] && v[29] && (i >= 4));
    checks++;
    if (beat_valid !== 1'b1 || beat_drive !== ed || beat_dc !== edc ||
        (!edc && beat_col !== ec)) begin
      errors++;
      $display("FAIL %s beat %0d: valid=%b col=%0d drive=%b dc=%b, expected valid=1 col=%0d drive=%b dc=%b",
               tag, i, beat_valid, beat_col, beat_drive, beat_dc, ec, ed, edc);
    end
  endtask

  task automatic check_idle(string tag);
    checks++;
    if (beat_valid !== 1'b0 || beat_drive !== 1'b0 || beat_dc !== 1'b0 || cmd_err !== 1'b0) begin
      errors++;
      $display("FAIL %s idle: valid=%b drive=%b dc=%b err=%b, expected all 0",
               tag, beat_valid, beat_drive, beat_dc, cmd_err);
    end
  endtask

  task automatic check_err(logic exp, string tag);
    checks++;
    if (cmd_err !== exp) begin
      errors++;
      $display("FAIL %s cmd_err=%b, expected %b", tag, cmd_err, exp);
    end
  endtask

  task automatic put_cmd(vec_t v);
    cmd_valid = 1'b1;
    cmd_rd    = v[29];
    cmd_ilv   = v[28];
    cmd_chop  = v[27];
    cmd_col   = v[26:24];
  endtask

  // One isolated burst, then the slot after it must be idle (R7, R10).
  task automatic play(vec_t v);
    @(negedge clk) put_cmd(v);
    @(negedge clk) cmd_valid = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i > 0) @(negedge clk);
      check_beat(v, i, tag_of(v));
    end
    @(negedge clk) check_idle("R7");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
  end

  initial begin
    rst = 1'b1; cmd_valid = 1'b0; cmd_rd = 1'b0; cmd_ilv = 1'b0;
    cmd_chop = 1'b0; cmd_col = 3'd0;
    repeat (3) @(negedge clk);
    check_idle("R1");
    rst = 1'b0;
    @(negedge clk) check_idle("R10");

    // Table walk
    for (int k = 0; k < NV; k++) play(VECS[k]);

    // R8: strobe in beat 7 chains the next burst with no gap
    @(negedge clk) put_cmd(VECS[0]);
    @(negedge clk) cmd_valid = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i > 0) @(negedge clk);
      check_beat(VECS[0], i, "R8");
    end
    put_cmd(VECS[7]);
    @(negedge clk) cmd_valid = 1'b0;
    check_err(1'b0, "R8");
    for (int i = 0; i < 8; i++) begin
      if (i > 0) @(negedge clk);
      check_beat(VECS[7], i, "R8");
    end
    @(negedge clk) check_idle("R7");

    // R9: strobe in slot 2 is rejected, burst unchanged, no extra burst
    @(negedge clk) put_cmd(VECS[1]);
    @(negedge clk) cmd_valid = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i > 0) @(negedge clk);
      check_beat(VECS[1], i, "R9");
      if (i == 2) put_cmd(VECS[9]);
      if (i == 3) begin
        cmd_valid = 1'b0;
        check_err(1'b1, "R9");
      end
    end
    @(negedge clk) check_idle("R9");

    // R1: reset in the middle of a burst
    @(negedge clk) put_cmd(VECS[3]);
    @(negedge clk) cmd_valid = 1'b0;
    check_beat(VECS[3], 0, "R1");
    @(negedge clk) check_beat(VECS[3], 1, "R1");
    rst = 1'b1;
    @(negedge clk) check_idle("R1");
    rst = 1'b0;
    @(negedge clk) check_idle("R1");

    // Chopped write after reset, low start bits ignored (R6)
    play({1'b0, 1'b0, 1'b1, 3'd5, 24'o45670000});

    summary();
  end

endmodule